// File: doc/BRIEF.md
# Dual-Width Instruction Fetch Unit

This block is the front end of a processor's fetch stage. It owns the program counter, turns it into a word-aligned instruction-memory address, and loads the 32-bit word that comes back into a fetch register. The register goes to the decode stage together with a valid bit. Instruction memory is assumed to answer within the same cycle. The core runs either full 32-bit instructions or a compressed mode of 16-bit instructions, and a mode input selects between them.

In 32-bit mode the PC moves by four on each cycle that completes a fetch. In 16-bit mode it moves by two. When the PC sits at the start of a word in 16-bit mode, the captured word holds a packed pair of halfword instructions. When the PC sits in the upper half of a word, only that upper halfword is presented, zero-extended. Before each fetch the PC is checked against an inclusive legal window and against the alignment rule of the current mode. A failing check raises a sticky exception and freezes the PC until a redirect supplies a new target. A redirect always wins over a stall.

Top module: `dual_fetch_unit`

## Requirements
- R1: While rst_n is low at a rising edge, the PC is set to RESET_PC (default 0), and fetch_valid and fetch_exc are both cleared.
- R2: In 32-bit mode (mode16=0), a cycle that fetches loads fetch_word with imem_rdata, sets fetch_valid, and adds 4 to the PC.
- R3: In 16-bit mode with PC bit 1 equal to 0, a fetch cycle loads the whole 32-bit word into fetch_word (two halfword instructions, the one at the lower address in bits 15:0), sets fetch_valid, and adds 2 to the PC.
- R4: In 16-bit mode with PC bit 1 equal to 1, a fetch cycle loads fetch_word with 16 zero bits above bits 31:16 of the word that contains the PC, sets fetch_valid, and adds 2 to the PC.
- R5: imem_addr always equals the PC with its two low bits forced to zero, and next_pc always equals the PC.
- R6: A fetch cycle is a violation when the PC is below lo_bound, above hi_bound (both bounds inclusive), has nonzero bits 1:0 in 32-bit mode, or has bit 0 set in 16-bit mode. On the next cycle fetch_exc is 1, fetch_valid is 0, and the PC and fetch_word are unchanged.
- R7: While fetch_exc is set and no redirect arrives, the PC, fetch_word and fetch_exc stay unchanged and fetch_valid stays 0, whatever the stall and mode inputs do.
- R8: With stall high and redirect low, the PC, fetch_word, fetch_valid and fetch_exc keep their values.
- R9: A redirect loads redirect_pc into the PC and clears fetch_valid and fetch_exc on the next cycle, even when stall is high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mode16 | input | 1 | 1 selects compressed 16-bit mode, 0 selects 32-bit mode |
| stall | input | 1 | Hold the PC and the fetch register |
| redirect | input | 1 | Load redirect_pc into the PC |
| redirect_pc | input | AW | Jump target |
| lo_bound | input | AW | Lowest legal fetch address (inclusive) |
| hi_bound | input | AW | Highest legal fetch address (inclusive) |
| imem_addr | output | AW | Word-aligned instruction-memory address |
| imem_rdata | input | 32 | Word returned by instruction memory in the same cycle |
| fetch_word | output | 32 | Fetch register |
| fetch_valid | output | 1 | Fetch register holds a fresh fetch |
| fetch_exc | output | 1 | Address violation exception, sticky until a redirect |
| next_pc | output | AW | Current PC, the address of the next fetch |

## Verification
Three controls can arrive in the same cycle: a redirect, a stall, and an address violation that is raised or already pending. They fight over one PC register and one fetch register. The bench drives random streams in which redirects, some of them to misaligned or out-of-window targets, land while stall is held and while the trap is pending. It also starts with a directed cycle where stall and redirect rise together. A bench model that applies the stated priority (redirect, then stall, then the pending trap, then a new violation, then the normal step) predicts the PC, the valid bit, the exception flag and the fetch word for every cycle. Each mismatch is reported under the requirement that the model's priority picked for that cycle.

// File: rtl/fetch_pkg.sv
// Package: shared action encoding for the dual-width fetch unit.
// Assumes: one action is chosen per cycle by the top-level control.
package fetch_pkg;
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,  // keep PC and fetch register
        ACT_LOAD = 2'd1,  // take the redirect target
        ACT_STEP = 2'd2,  // fetch and advance
        ACT_TRAP = 2'd3   // violation: raise exception, keep PC
    } fetch_act_e;
endpackage

// File: rtl/fu_addr_check.sv
// Module: fu_addr_check
// Flags a fetch address that lies outside the inclusive window or breaks
// the alignment rule of the current mode (32-bit: bits 1:0 zero,
// 16-bit: bit 0 zero). Purely combinational.
module fu_addr_check #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] pc,
    input  logic          mode16,
    input  logic [AW-1:0] lo_bound,
    input  logic [AW-1:0] hi_bound,
    output logic          viol
);
    logic out_of_window;
    logic misaligned;

    // Range and alignment tests, combined into one violation flag.
    always_comb begin
        out_of_window = (pc < lo_bound) || (pc > hi_bound);
        misaligned    = mode16 ? pc[0] : (pc[1:0] != 2'b00);
        viol          = out_of_window || misaligned;
    end
endmodule

// File: rtl/fu_pc_gen.sv
// Module: fu_pc_gen
// Holds the program counter. It loads a redirect target, steps by 2 or 4
// depending on mode, or holds. Assumes the action is decided upstream.
module fu_pc_gen
    import fetch_pkg::*;
#(
    parameter int          AW       = 32,
    parameter logic [AW-1:0] RESET_PC = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  fetch_act_e    act,
    input  logic          mode16,
    input  logic [AW-1:0] target,
    output logic [AW-1:0] pc
);
    localparam logic [AW-1:0] STEP_HALF = AW'(2);
    localparam logic [AW-1:0] STEP_WORD = AW'(4);

    // PC register update per chosen action.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= RESET_PC;
        end else begin
            case (act)
                ACT_LOAD: pc <= target;
                ACT_STEP: pc <= pc + (mode16 ? STEP_HALF : STEP_WORD);
                default:  pc <= pc;
            endcase
        end
    end

    p_step_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_STEP && !mode16) |=> pc == $past(pc) + STEP_WORD);
    p_step_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_STEP && mode16) |=> pc == $past(pc) + STEP_HALF);
    p_load_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_LOAD) |=> pc == $past(target));
endmodule

// File: rtl/fu_fetch_reg.sv
// Module: fu_fetch_reg
// Fetch register with valid bit and sticky exception flag. In 16-bit mode
// a word fetched at a word-aligned PC is also kept, so the following
// upper-half fetch can reuse it. Assumes memory data is valid in the
// same cycle as the address.
module fu_fetch_reg
    import fetch_pkg::*;
#(
    parameter int WW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  fetch_act_e    act,
    input  logic          mode16,
    input  logic          upper_half,
    input  logic [WW-1:0] rdata,
    output logic [WW-1:0] word,
    output logic          valid,
    output logic          exc
);
    localparam int HW = WW / 2;

    logic [WW-1:0] held_word;
    logic          held_ok;
    logic [HW-1:0] upper_src;

    // Source of the single upper-half instruction: kept word if valid.
    always_comb upper_src = held_ok ? held_word[WW-1:HW] : rdata[WW-1:HW];

    // Register update for fetch word, valid, exception and kept word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word      <= '0;
            valid     <= 1'b0;
            exc       <= 1'b0;
            held_word <= '0;
            held_ok   <= 1'b0;
        end else begin
            case (act)
                ACT_LOAD: begin
                    valid   <= 1'b0;
                    exc     <= 1'b0;
                    held_ok <= 1'b0;
                end
                ACT_TRAP: begin
                    valid <= 1'b0;
                    exc   <= 1'b1;
                end
                ACT_STEP: begin
                    valid <= 1'b1;
                    if (!mode16) begin
                        word    <= rdata;
                        held_ok <= 1'b0;
                    end else if (!upper_half) begin
                        word      <= rdata;
                        held_word <= rdata;
                        held_ok   <= 1'b1;
                    end else begin
                        word    <= {{HW{1'b0}}, upper_src};
                        held_ok <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    p_exc_no_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        exc |-> !valid);
    p_pair_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_STEP && mode16 && !upper_half) |=> word == $past(rdata));
    p_single_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_STEP && mode16 && upper_half)
        |=> word == {{HW{1'b0}}, $past(rdata[WW-1:HW])});
    p_trap_keeps_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_TRAP) |=> ($stable(word) && exc));
endmodule

// File: rtl/dual_fetch_unit.sv
// Module: dual_fetch_unit
// Fetch-stage front end for 32-bit and compressed 16-bit modes. It picks
// one action per cycle: redirect over stall, stall over a pending trap,
// a pending trap over a new violation, and a new violation over a normal
// fetch. Assumes instruction memory returns data in the same cycle.
module dual_fetch_unit
    import fetch_pkg::*;
#(
    parameter int            AW       = 32,
    parameter logic [AW-1:0] RESET_PC = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode16,
    input  logic          stall,
    input  logic          redirect,
    input  logic [AW-1:0] redirect_pc,
    input  logic [AW-1:0] lo_bound,
    input  logic [AW-1:0] hi_bound,
    output logic [AW-1:0] imem_addr,
    input  logic [31:0]   imem_rdata,
    output logic [31:0]   fetch_word,
    output logic          fetch_valid,
    output logic          fetch_exc,
    output logic [AW-1:0] next_pc
);
    localparam int WW = 32;

    logic [AW-1:0] pc;
    logic          viol;
    fetch_act_e    act;

    fu_addr_check #(.AW(AW)) u_check (
        .pc       (pc),
        .mode16   (mode16),
        .lo_bound (lo_bound),
        .hi_bound (hi_bound),
        .viol     (viol)
    );

    // Per-cycle action select in priority order.
    always_comb begin
        if (redirect)       act = ACT_LOAD;
        else if (stall)     act = ACT_HOLD;
        else if (fetch_exc) act = ACT_HOLD;
        else if (viol)      act = ACT_TRAP;
        else                act = ACT_STEP;
    end

    fu_pc_gen #(.AW(AW), .RESET_PC(RESET_PC)) u_pc (
        .clk    (clk),
        .rst_n  (rst_n),
        .act    (act),
        .mode16 (mode16),
        .target (redirect_pc),
        .pc     (pc)
    );

    fu_fetch_reg #(.WW(WW)) u_freg (
        .clk        (clk),
        .rst_n      (rst_n),
        .act        (act),
        .mode16     (mode16),
        .upper_half (pc[1]),
        .rdata      (imem_rdata),
        .word       (fetch_word),
        .valid      (fetch_valid),
        .exc        (fetch_exc)
    );

    // Word-aligned memory address and PC observation.
    always_comb begin
        imem_addr = {pc[AW-1:2], 2'b00};
        next_pc   = pc;
    end

    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !redirect) |=> ($stable(next_pc) && $stable(fetch_word)
                                  && $stable(fetch_valid) && $stable(fetch_exc)));
    p_redirect_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> (next_pc == $past(redirect_pc) && !fetch_valid && !fetch_exc));
    p_trap_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_exc && !redirect) |=> ($stable(next_pc) && fetch_exc));
    p_addr_follows_pc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        imem_addr[AW-1:2] == next_pc[AW-1:2]);
endmodule

// File: tb/dual_fetch_unit_test.sv
module dual_fetch_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int N_CYCLES = 4000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode16 = 1'b0, stall = 1'b0, redirect = 1'b0;
    logic [AW-1:0] redirect_pc = '0;
    logic [AW-1:0] lo_bound = 32'h100, hi_bound = 32'h1FF;
    logic [AW-1:0] imem_addr, next_pc;
    logic [31:0]   imem_rdata, fetch_word;
    logic          fetch_valid, fetch_exc;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Expected state, built from the requirements.
    logic [AW-1:0] m_pc;
    logic [31:0]   m_word;
    logic          m_valid, m_exc;
    string         m_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] mem_fn(input logic [AW-1:0] a);
        return (a * 32'h9E3779B1) ^ 32'h5A5A0000 ^ {a[15:0], a[31:16]};
    endfunction

    assign imem_rdata = mem_fn(imem_addr);

    dual_fetch_unit uut (
        .clk(clk), .rst_n(rst_n), .mode16(mode16), .stall(stall),
        .redirect(redirect), .redirect_pc(redirect_pc),
        .lo_bound(lo_bound), .hi_bound(hi_bound),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .fetch_word(fetch_word), .fetch_valid(fetch_valid),
        .fetch_exc(fetch_exc), .next_pc(next_pc)
    );

    function automatic bit bad_addr(input logic [AW-1:0] a, input logic m16,
                                    input logic [AW-1:0] lo, input logic [AW-1:0] hi);
        return (a < lo) || (a > hi) || (m16 ? a[0] : (a[1:0] != 2'b00));
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Compare all outputs against the expected state (called at negedge).
    task automatic compare_all(input string tag);
        chk(tag, "next_pc", next_pc, m_pc);
        chk(tag, "fetch_valid", {31'b0, fetch_valid}, {31'b0, m_valid});
        chk(tag, "fetch_exc", {31'b0, fetch_exc}, {31'b0, m_exc});
        chk(tag, "fetch_word", fetch_word, m_word);
        chk("R5", "imem_addr", imem_addr, {m_pc[AW-1:2], 2'b00});
    endtask

    // Advance the expected state by one clock with the driven inputs.
    task automatic model_step();
        logic [31:0] w;
        w = mem_fn({m_pc[AW-1:2], 2'b00});
        if (redirect) begin
            m_tag = "R9"; m_pc = redirect_pc; m_valid = 0; m_exc = 0;
        end else if (stall) begin
            m_tag = "R8";
        end else if (m_exc) begin
            m_tag = "R7";
        end else if (bad_addr(m_pc, mode16, lo_bound, hi_bound)) begin
            m_tag = "R6"; m_exc = 1; m_valid = 0;
        end else if (!mode16) begin
            m_tag = "R2"; m_word = w; m_valid = 1; m_pc = m_pc + 4;
        end else if (!m_pc[1]) begin
            m_tag = "R3"; m_word = w; m_valid = 1; m_pc = m_pc + 2;
        end else begin
            m_tag = "R4"; m_word = {16'h0, w[31:16]}; m_valid = 1; m_pc = m_pc + 2;
        end
    endtask

    task automatic cycle();
        model_step();
        @(negedge clk);
        compare_all(m_tag);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd7));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_pc = '0; m_word = '0; m_valid = 0; m_exc = 0;
        // R1: reset state.
        compare_all("R1");

        // Directed: stall and redirect together, redirect wins (R9).
        stall = 1; redirect = 1; redirect_pc = 32'h100;
        cycle();
        stall = 0; redirect = 0;
        // R2: a few 32-bit fetches.
        repeat (3) cycle();
        // R3 / R4: switch to 16-bit mode, alternate halves.
        mode16 = 1;
        repeat (4) cycle();
        // R6: redirect to an odd 16-bit address, then trap.
        redirect = 1; redirect_pc = 32'h121; cycle();
        redirect = 0; cycle();
        // R7: trap held through stall and mode change.
        stall = 1; cycle(); stall = 0; mode16 = 0; cycle(); cycle();
        // R4 first after redirect: upper half without kept word.
        mode16 = 1; redirect = 1; redirect_pc = 32'h1FA; cycle();
        redirect = 0; repeat (4) cycle();  // R6 at hi_bound + 1
        // R6: 32-bit misaligned but in range.
        mode16 = 0; redirect = 1; redirect_pc = 32'h102; cycle();
        redirect = 0; cycle();

        // Random phase.
        for (int i = 0; i < N_CYCLES; i++) begin
            int r;
            r = $urandom % 16;
            stall = ($urandom % 5) == 0;
            redirect = (r < 2) || (m_exc && (r < 6));
            if (($urandom % 24) == 0) mode16 = ~mode16;
            case ($urandom % 8)
                0: redirect_pc = 32'h80 + ($urandom % 64);
                1: redirect_pc = 32'h1F0 + ($urandom % 16);
                2: redirect_pc = 32'h100 + ($urandom % 256);
                default: redirect_pc = 32'h100 + (($urandom % 64) << 2)
                                      + (mode16 ? (($urandom % 2) << 1) : 0);
            endcase
            cycle();
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule